// File: doc/BRIEF.md
# Exception mode-bit stack register

This block keeps a processor's privilege bit, interrupt-enable bit and the two cache auto-lock bits. Each kind of bit is held in a three-level stack whose levels are called current, previous and old. Taking an exception pushes every stack in a single clock. The current level is forced to the safe state: kernel mode, interrupts off, both auto-locks off. Because there are three levels, two exceptions can nest before software saves the words, and the original mode is still held.

A return-from-exception strobe pops the stacks. Software can load either word through a write port. Two packed views are driven continuously. The status view holds the privilege and interrupt-enable pairs. The cache-control view holds the data-cache and instruction-cache auto-lock pairs.

Top module: `excmode_stack`

## Requirements
- R1: After reset, both words read as all zeros.
- R2: When `exc_take_i` is high, the status pairs shift one level in one clock: current goes to previous and previous goes to old.
- R3: On an exception, the current privilege bit and the current interrupt-enable bit both become 0.
- R4: The same exception shifts the cache auto-lock pairs one level in the same way and clears the current data-lock and instruction-lock bits to 0.
- R5: The status word layout is as follows. Bit 0 is interrupt-enable current and bit 1 is privilege current. Bits 2 and 3 hold the previous pair, with interrupt-enable in bit 2. Bits 4 and 5 hold the old pair, with interrupt-enable in bit 4. Bits 31..6 read 0 and ignore writes.
- R6: The cache word layout is as follows. Bit 8 is data-lock current and bit 9 is instruction-lock current. Bits 10 and 11 hold the previous pair, with data-lock in bit 10. Bits 12 and 13 hold the old pair, with data-lock in bit 12. Bits 31..14 and 7..0 read 0 and ignore writes.
- R7: On a return strobe, each stack pops: previous goes to current, old goes to previous, and old keeps its value.
- R8: A write strobe loads the named word's field from `sw_wdata_i`. The result is visible in the next cycle.
- R9: An exception in the same cycle as a write or a return performs only the push.
- R10: A write and a return in the same cycle are resolved per word. A word being written takes the write value. The other word pops.
- R11: Two nested exceptions followed by two returns bring back the current bits that were held before the first exception.
- R12: With no strobe, both words hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_take_i | input | 1 | Exception taken: push all stacks |
| exc_return_i | input | 1 | Return from exception: pop all stacks |
| wr_stat_i | input | 1 | Load the status field from write data |
| wr_cache_i | input | 1 | Load the cache-lock field from write data |
| sw_wdata_i | input | 32 | Software write data, in word layout |
| stat_word_o | output | 32 | Packed status view |
| cache_word_o | output | 32 | Packed cache-control view |

## Verification
A level that is lost or shifted the wrong way shows up in the packed word one clock after the strobe. At that point the pair appears at the wrong bit position, or it is not zeroed. A fault in the pop path can stay hidden until a return. The nested sequence therefore runs two returns and compares the restored current bits against the values held before the first exception. A wrong priority between strobes shows up as a load value or a popped value in a cycle where only the push should have acted.

// File: rtl/excmode_pkg.sv
package excmode_pkg;
  localparam int unsigned PAIR_W = 2;
  localparam int unsigned LEVELS = 3;
  localparam int unsigned FIELD_W = PAIR_W * LEVELS;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic load;
  } stack_cmd_t;

  // place a field into a word of width 32 at bit lsb
  function automatic logic [31:0] place_field(field_t f, int unsigned lsb);
    logic [31:0] w;
    w = '0;
    w[lsb +: FIELD_W] = f;
    return w;
  endfunction
endpackage

// File: rtl/excmode_evt_ctrl.sv
module excmode_evt_ctrl
  import excmode_pkg::*;
(
  input  logic       exc_take_i,
  input  logic       exc_return_i,
  input  logic       wr_stat_i,
  input  logic       wr_cache_i,
  output stack_cmd_t stat_cmd_o,
  output stack_cmd_t cache_cmd_o
);
  // priority: exception push, then write per word, then pop
  always_comb begin
    stat_cmd_o.push  = exc_take_i;
    stat_cmd_o.load  = wr_stat_i & ~exc_take_i;
    stat_cmd_o.pop   = exc_return_i & ~exc_take_i & ~wr_stat_i;
    cache_cmd_o.push = exc_take_i;
    cache_cmd_o.load = wr_cache_i & ~exc_take_i;
    cache_cmd_o.pop  = exc_return_i & ~exc_take_i & ~wr_cache_i;
  end
endmodule

// File: rtl/excmode_pair_stack.sv
module excmode_pair_stack
  import excmode_pkg::*;
#(
  parameter int unsigned W     = PAIR_W,
  parameter int unsigned DEPTH = LEVELS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  stack_cmd_t         cmd_i,
  input  logic [W*DEPTH-1:0] load_i,
  output logic [W*DEPTH-1:0] lvls_o
);
  logic [W*DEPTH-1:0] lvl_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
    logic [W-1:0] below, above;
    if (k == 0) begin : g_bot
      assign below = '0;
    end else begin : g_mid
      assign below = lvl_q[(k-1)*W +: W];
    end
    if (k == DEPTH-1) begin : g_top
      assign above = lvl_q[k*W +: W];
    end else begin : g_low
      assign above = lvl_q[(k+1)*W +: W];
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni)          lvl_q[k*W +: W] <= '0;
      else if (cmd_i.push)  lvl_q[k*W +: W] <= below;
      else if (cmd_i.load)  lvl_q[k*W +: W] <= load_i[k*W +: W];
      else if (cmd_i.pop)   lvl_q[k*W +: W] <= above;
    end
  end

  assign lvls_o = lvl_q;
endmodule

// File: rtl/excmode_stack.sv
module excmode_stack
  import excmode_pkg::*;
#(
  parameter int unsigned STAT_LSB  = 0,
  parameter int unsigned CACHE_LSB = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        exc_take_i,
  input  logic        exc_return_i,
  input  logic        wr_stat_i,
  input  logic        wr_cache_i,
  input  logic [31:0] sw_wdata_i,
  output logic [31:0] stat_word_o,
  output logic [31:0] cache_word_o
);
  stack_cmd_t stat_cmd, cache_cmd;
  field_t     stat_f, cache_f;
  logic       wdata_unused;

  assign wdata_unused = ^sw_wdata_i;

  excmode_evt_ctrl u_ctrl (
    .exc_take_i  (exc_take_i),
    .exc_return_i(exc_return_i),
    .wr_stat_i   (wr_stat_i),
    .wr_cache_i  (wr_cache_i),
    .stat_cmd_o  (stat_cmd),
    .cache_cmd_o (cache_cmd)
  );

  // pair {privilege, irq enable}
  excmode_pair_stack u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (stat_cmd),
    .load_i(sw_wdata_i[STAT_LSB +: FIELD_W]),
    .lvls_o(stat_f)
  );

  // pair {instr lock, data lock}
  excmode_pair_stack u_cache (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cache_cmd),
    .load_i(sw_wdata_i[CACHE_LSB +: FIELD_W]),
    .lvls_o(cache_f)
  );

  assign stat_word_o  = place_field(stat_f, STAT_LSB);
  assign cache_word_o = place_field(cache_f, CACHE_LSB);
endmodule

// File: rtl/excmode_stack_chk.sv
module excmode_stack_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exc_take_i,
  input logic        exc_return_i,
  input logic        wr_stat_i,
  input logic        wr_cache_i,
  input logic [31:0] sw_wdata_i,
  input logic [31:0] stat_word_o,
  input logic [31:0] cache_word_o
);
  logic s_pop, c_pop, idle;
  assign s_pop = exc_return_i & ~exc_take_i & ~wr_stat_i;
  assign c_pop = exc_return_i & ~exc_take_i & ~wr_cache_i;
  assign idle  = ~exc_take_i & ~exc_return_i & ~wr_stat_i & ~wr_cache_i;

  a_r1_reset_zero: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (stat_word_o == 32'd0 && cache_word_o == 32'd0));
  a_r2_stat_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_i |=> stat_word_o[5:2] == $past(stat_word_o[3:0]));
  a_r3_stat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_i |=> stat_word_o[1:0] == 2'b00);
  a_r4_cache_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_i |=> (cache_word_o[13:10] == $past(cache_word_o[11:8]) &&
                    cache_word_o[9:8] == 2'b00));
  a_r5_r6_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word_o[31:6] == '0 && cache_word_o[31:14] == '0 && cache_word_o[7:0] == '0);
  a_r7_stat_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_pop |=> (stat_word_o[1:0] == $past(stat_word_o[3:2]) &&
               stat_word_o[5:2] == $past({stat_word_o[5:4], stat_word_o[5:4]})));
  a_r7_cache_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_pop |=> (cache_word_o[9:8] == $past(cache_word_o[11:10]) &&
               cache_word_o[13:10] == $past({cache_word_o[13:12], cache_word_o[13:12]})));
  a_r8_stat_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && !exc_take_i) |=> stat_word_o[5:0] == $past(sw_wdata_i[5:0]));
  a_r8_cache_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cache_i && !exc_take_i) |=> cache_word_o[13:8] == $past(sw_wdata_i[13:8]));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ($stable(stat_word_o) && $stable(cache_word_o)));
endmodule

bind excmode_stack excmode_stack_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_take_i  (exc_take_i),
  .exc_return_i(exc_return_i),
  .wr_stat_i   (wr_stat_i),
  .wr_cache_i  (wr_cache_i),
  .sw_wdata_i  (sw_wdata_i),
  .stat_word_o (stat_word_o),
  .cache_word_o(cache_word_o)
);

// File: tb/excmode_stack_tb.sv
module excmode_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc, ret, ws, wc;
  logic [31:0] wdata;
  logic [31:0] stat_w, cache_w;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] st;
    logic [31:0] ca;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [5:0] m_st, m_ca;

  always #10 clk = ~clk;

  excmode_stack dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exc_take_i(exc), .exc_return_i(ret),
    .wr_stat_i(ws), .wr_cache_i(wc), .sw_wdata_i(wdata),
    .stat_word_o(stat_w), .cache_word_o(cache_w)
  );

  task automatic compare(logic [31:0] st, logic [31:0] ca, string tag);
    checks++;
    if (stat_w !== st || cache_w !== ca) begin
      errors++;
      $display("FAIL %s: stat=%h cache=%h expected stat=%h cache=%h",
               tag, stat_w, cache_w, st, ca);
    end
  endtask

  // model of one stack: {old, prev, cur}, two bits each
  function automatic logic [5:0] next_lvl(logic [5:0] cur, logic e, logic w,
                                          logic r, logic [5:0] d);
    if (e)      return {cur[3:0], 2'b00};
    else if (w) return d;
    else if (r) return {cur[5:4], cur[5:4], cur[3:2]};
    return cur;
  endfunction

  task automatic drive(logic e, logic r, logic s, logic c, logic [31:0] d, string tag);
    exp_t x;
    @(negedge clk);
    exc = e; ret = r; ws = s; wc = c; wdata = d;
    m_st = next_lvl(m_st, e, s, r, d[5:0]);
    m_ca = next_lvl(m_ca, e, c, r, d[13:8]);
    @(posedge clk);
    #1;
    exc = 0; ret = 0; ws = 0; wc = 0; wdata = '0;
    x.st = {26'd0, m_st};
    x.ca = {18'd0, m_ca, 8'd0};
    x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: pop expected items after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        compare(x.st, x.ca, x.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] orig_cur_s, orig_cur_c;
    rst_n = 0; exc = 0; ret = 0; ws = 0; wc = 0; wdata = '0;
    m_st = '0; m_ca = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare(32'd0, 32'd0, "R1 reset");

    // R5 R6: writes, out-of-field bits ignored
    drive(0, 0, 1, 1, 32'hFFFF_FFFF, "R5 R6 R8 write all ones");
    drive(0, 0, 1, 1, 32'h0000_1B2E, "R8 write pattern");
    drive(0, 0, 0, 0, 32'd0, "R12 hold");
    drive(0, 0, 1, 0, 32'h0000_0003, "R5 status current pair only");
    drive(0, 0, 0, 1, 32'h0000_0300, "R6 cache current pair only");
    // R2 R3 R4: single exception
    drive(1, 0, 0, 0, 32'd0, "R2 R3 R4 exception push");
    drive(0, 1, 0, 0, 32'd0, "R7 return pop");
    // R11 nested
    drive(0, 0, 1, 1, 32'h0000_0200 | 32'h1, "R8 set original mode");
    @(negedge clk);
    orig_cur_s = stat_w[5:0];
    orig_cur_c = cache_w[13:8];
    drive(1, 0, 0, 0, 32'd0, "R11 first exception");
    drive(1, 0, 0, 0, 32'd0, "R11 second exception");
    drive(0, 1, 0, 0, 32'd0, "R11 first return");
    drive(0, 1, 0, 0, 32'd0, "R11 second return");
    @(negedge clk);
    checks++;
    if (stat_w[1:0] !== orig_cur_s[1:0] || cache_w[9:8] !== orig_cur_c[1:0]) begin
      errors++;
      $display("FAIL R11 restore: cur stat=%b cache=%b expected stat=%b cache=%b",
               stat_w[1:0], cache_w[9:8], orig_cur_s[1:0], orig_cur_c[1:0]);
    end
    // R9 priorities
    drive(0, 0, 1, 1, 32'h0000_2D1B, "R8 preload");
    drive(1, 0, 1, 1, 32'h0000_3F3F, "R9 exception beats write");
    drive(1, 1, 0, 0, 32'd0, "R9 exception beats return");
    drive(0, 0, 1, 1, 32'h0000_3A36, "R8 preload 2");
    // R10: status written, cache pops
    drive(0, 1, 1, 0, 32'h0000_1515, "R10 write beats return on status");
    drive(0, 1, 0, 1, 32'h0000_0C00, "R10 write beats return on cache");
    drive(0, 0, 0, 0, 32'hFFFF_FFFF, "R12 idle with data");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule